// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a translation-cache miss by walking a two-level page table held in memory. A walk request carries a full virtual address and the physical base address of the first-level table. The virtual page number is split into two indices. The upper index selects an entry in the first-level table. That entry names the frame that holds the second-level table, and the lower index selects an entry inside that frame. The second-level entry supplies the physical frame number and the page attributes.

The walker makes one read per level through a request/response memory port. A read cannot start before the entry of the level above has returned, so at most one read is outstanding at a time. The request side uses a valid/ready handshake. The response arrives after any number of cycles. If the entry fetched at either level has its valid bit clear, the walk stops at once and the walker reports a page fault instead of a translation. When a walk completes, the walker returns the frame number, the read/write/execute permissions, the dirty and reference bits, and the physical address. That address is the frame number joined to the untranslated page offset.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready` is 1, and `mem_req_valid`, `walk_done` and `walk_fault` are all 0.
- R2: The first read of a walk goes to `req_base + 4 * req_vaddr[31:22]`. While `mem_req_ready` is low, `mem_req_valid` stays high and `mem_req_addr` does not change.
- R3: On a successful walk exactly two reads are made. The second read goes to `{L1entry[31:12], 12'h000} + 4 * req_vaddr[21:12]` and is issued only after the first response has returned.
- R4: Entry format: bit 0 valid, bit 1 read, bit 2 write, bit 3 execute, bit 4 reference, bit 5 dirty, bits 31:12 frame number. A successful walk raises `walk_done` with `res_pfn` = L2entry[31:12], `res_perm` = {execute, write, read}, and `res_dirty` and `res_ref` taken from the second-level entry.
- R5: A first-level entry with valid = 0 ends the walk after one read. The walker then raises `walk_fault` with `fault_lvl` = 0 and issues no second read.
- R6: A second-level entry with valid = 0 ends the walk after two reads. The walker then raises `walk_fault` with `fault_lvl` = 1.
- R7: `req_ready` is 1 only while the walker is idle. A request presented during a walk is ignored, and the result and the read addresses belong to the walk already in progress.
- R8: `walk_done` and `walk_fault` are never high together. Each is a single-cycle pulse.
- R9: The result of a walk does not depend on how long `mem_req_ready` is held low or on the response latency.
- R10: `res_paddr` equals `{res_pfn, req_vaddr[11:0]}`, so the page offset passes through untranslated.
- R11: Only the valid bit and the frame field of a first-level entry affect the walk. Its permission, dirty and reference bits have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Walk request present |
| req_ready | output | 1 | Walker idle, request accepted |
| req_vaddr | input | 32 | Virtual address to translate |
| req_base | input | 32 | Physical base of the first-level table |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Page table entry read |
| walk_done | output | 1 | One-cycle pulse: translation complete |
| walk_fault | output | 1 | One-cycle pulse: page fault |
| fault_lvl | output | 1 | Level whose entry was invalid (0 first, 1 second) |
| res_pfn | output | 20 | Translated frame number |
| res_paddr | output | 32 | Translated physical address |
| res_perm | output | 3 | {execute, write, read} permissions |
| res_dirty | output | 1 | Dirty bit of the final entry |
| res_ref | output | 1 | Reference bit of the final entry |

## Verification
The bench builds the walker with its default geometry: 10-bit indices at both levels, a 12-bit offset and 32-bit entries. With this geometry the index extremes 0 and 1023 can be reached at each level, as can an all-ones frame number and table bases at arbitrary frames of a small modelled memory. The memory model can run with ready always high or with ready low two cycles out of three, and with a response latency from zero to several cycles. These settings exercise the stall and latency cases of the handshake against the same table contents. Faults are placed at each level, and a first-level entry with all attribute bits set shows that those bits do not reach the result.

// File: rtl/pt_pkg.sv
package pt_pkg;

  localparam int unsigned FLAG_W    = 6;
  localparam int unsigned BIT_VALID = 0;
  localparam int unsigned BIT_RD    = 1;
  localparam int unsigned BIT_WR    = 2;
  localparam int unsigned BIT_EX    = 3;
  localparam int unsigned BIT_REF   = 4;
  localparam int unsigned BIT_DIRTY = 5;

  typedef struct packed {
    logic dirty;
    logic refd;
    logic ex;
    logic wr;
    logic rd;
    logic valid;
  } pte_flags_t;

  typedef enum logic [2:0] {
    WS_IDLE,
    WS_L1_REQ,
    WS_L1_WAIT,
    WS_L2_REQ,
    WS_L2_WAIT,
    WS_DONE,
    WS_FAULT
  } walk_state_e;

  function automatic pte_flags_t unpack_flags(input logic [FLAG_W-1:0] raw);
    pte_flags_t f;
    f.valid = raw[BIT_VALID];
    f.rd    = raw[BIT_RD];
    f.wr    = raw[BIT_WR];
    f.ex    = raw[BIT_EX];
    f.refd  = raw[BIT_REF];
    f.dirty = raw[BIT_DIRTY];
    return f;
  endfunction

endpackage

// File: rtl/pt_addr_gen.sv
module pt_addr_gen #(
  parameter int unsigned PA_W   = 32,
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned ENT_SH = 2
) (
  input  logic [PA_W-1:0]  table_base,
  input  logic [IDX_W-1:0] idx,
  output logic [PA_W-1:0]  entry_addr
);

  // byte address of slot idx in a table of 2**ENT_SH-byte entries
  function automatic logic [PA_W-1:0] slot_addr(input logic [PA_W-1:0] b,
                                                input logic [IDX_W-1:0] i);
    return b + (PA_W'(i) << ENT_SH);
  endfunction

  assign entry_addr = slot_addr(table_base, idx);

endmodule

// File: rtl/pt_pte_decode.sv
module pt_pte_decode
  import pt_pkg::*;
#(
  parameter int unsigned PTE_W = 32,
  parameter int unsigned OFF_W = 12,
  localparam int unsigned PFN_W = PTE_W - OFF_W,
  localparam int unsigned PA_W  = PFN_W + OFF_W
) (
  input  logic [PTE_W-1:0] raw,
  output logic [PFN_W-1:0] pfn,
  output logic [PA_W-1:0]  frame_base,
  output pte_flags_t       flags
);

  logic [OFF_W-1:0] low_bits;

  assign pfn        = raw[PTE_W-1:OFF_W];
  assign low_bits   = raw[OFF_W-1:0];
  assign frame_base = {pfn, {OFF_W{1'b0}}};
  assign flags      = unpack_flags(low_bits[FLAG_W-1:0]);

  // bits between the flags and the frame field are reserved
  logic unused_rsvd;
  assign unused_rsvd = ^low_bits[OFF_W-1:FLAG_W];

endmodule

// File: rtl/pt_walk_ctrl.sv
module pt_walk_ctrl
  import pt_pkg::*;
#(
  parameter int unsigned VA_W  = 32,
  parameter int unsigned PA_W  = 32,
  parameter int unsigned PFN_W = 20,
  parameter int unsigned OFF_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [PA_W-1:0]  req_base,
  output logic [VA_W-1:0]  vaddr_q,
  output logic [PA_W-1:0]  base_q,
  output logic [PA_W-1:0]  l2_base_q,
  input  logic [PA_W-1:0]  l1_addr,
  input  logic [PA_W-1:0]  l2_addr,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [PA_W-1:0]  mem_req_addr,
  input  logic             mem_rsp_valid,
  input  pte_flags_t       rsp_flags,
  input  logic [PFN_W-1:0] rsp_pfn,
  input  logic [PA_W-1:0]  rsp_frame,
  output logic             walk_done,
  output logic             walk_fault,
  output logic             fault_lvl,
  output logic [PFN_W-1:0] res_pfn,
  output logic [PA_W-1:0]  res_paddr,
  output logic [2:0]       res_perm,
  output logic             res_dirty,
  output logic             res_ref
);

  walk_state_e state_q;

  // named internal events for the assertions
  logic req_fire;
  logic l1_rsp_ev;
  logic l2_rsp_ev;
  logic l1_miss_ev;
  logic l2_miss_ev;

  assign req_fire   = req_valid && (state_q == WS_IDLE);
  assign l1_rsp_ev  = mem_rsp_valid && (state_q == WS_L1_WAIT);
  assign l2_rsp_ev  = mem_rsp_valid && (state_q == WS_L2_WAIT);
  assign l1_miss_ev = l1_rsp_ev && !rsp_flags.valid;
  assign l2_miss_ev = l2_rsp_ev && !rsp_flags.valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= WS_IDLE;
      vaddr_q   <= '0;
      base_q    <= '0;
      l2_base_q <= '0;
      fault_lvl <= 1'b0;
      res_pfn   <= '0;
      res_perm  <= '0;
      res_dirty <= 1'b0;
      res_ref   <= 1'b0;
    end else begin
      unique case (state_q)
        WS_IDLE: begin
          if (req_fire) begin
            vaddr_q <= req_vaddr;
            base_q  <= req_base;
            state_q <= WS_L1_REQ;
          end
        end
        WS_L1_REQ: if (mem_req_ready) state_q <= WS_L1_WAIT;
        WS_L1_WAIT: begin
          if (l1_miss_ev) begin
            fault_lvl <= 1'b0;
            state_q   <= WS_FAULT;
          end else if (l1_rsp_ev) begin
            l2_base_q <= rsp_frame;
            state_q   <= WS_L2_REQ;
          end
        end
        WS_L2_REQ: if (mem_req_ready) state_q <= WS_L2_WAIT;
        WS_L2_WAIT: begin
          if (l2_miss_ev) begin
            fault_lvl <= 1'b1;
            state_q   <= WS_FAULT;
          end else if (l2_rsp_ev) begin
            res_pfn   <= rsp_pfn;
            res_perm  <= {rsp_flags.ex, rsp_flags.wr, rsp_flags.rd};
            res_dirty <= rsp_flags.dirty;
            res_ref   <= rsp_flags.refd;
            state_q   <= WS_DONE;
          end
        end
        WS_DONE:  state_q <= WS_IDLE;
        WS_FAULT: state_q <= WS_IDLE;
        default:  state_q <= WS_IDLE;
      endcase
    end
  end

  assign req_ready     = (state_q == WS_IDLE);
  assign mem_req_valid = (state_q == WS_L1_REQ) || (state_q == WS_L2_REQ);
  assign mem_req_addr  = (state_q == WS_L2_REQ) ? l2_addr : l1_addr;
  assign walk_done     = (state_q == WS_DONE);
  assign walk_fault    = (state_q == WS_FAULT);
  assign res_paddr     = {res_pfn, vaddr_q[OFF_W-1:0]};

  // R8
  done_fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(walk_done && walk_fault));

  // R8
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_done || walk_fault) |=> !(walk_done || walk_fault));

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R5
  l1_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    l1_miss_ev |=> (walk_fault && !fault_lvl && !mem_req_valid));

  // R6
  l2_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    l2_miss_ev |=> (walk_fault && fault_lvl));

  // R7
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> !req_ready);

  // R3
  l2_needs_l1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (l1_rsp_ev && rsp_flags.valid) |=> (mem_req_valid && $stable(vaddr_q)));

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_pkg::*;
#(
  parameter int unsigned IDX1_W = 10,
  parameter int unsigned IDX2_W = 10,
  parameter int unsigned OFF_W  = 12,
  parameter int unsigned PTE_W  = 32,
  localparam int unsigned PFN_W = PTE_W - OFF_W,
  localparam int unsigned PA_W  = PFN_W + OFF_W,
  localparam int unsigned VA_W  = IDX1_W + IDX2_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [PA_W-1:0]  req_base,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [PA_W-1:0]  mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [PTE_W-1:0] mem_rsp_data,
  output logic             walk_done,
  output logic             walk_fault,
  output logic             fault_lvl,
  output logic [PFN_W-1:0] res_pfn,
  output logic [PA_W-1:0]  res_paddr,
  output logic [2:0]       res_perm,
  output logic             res_dirty,
  output logic             res_ref
);

  localparam int unsigned ENT_SH  = $clog2(PTE_W / 8);
  localparam int unsigned IDX_MAX = (IDX1_W > IDX2_W) ? IDX1_W : IDX2_W;
  localparam int unsigned LEVELS  = 2;

  logic [VA_W-1:0]    vaddr_q;
  logic [PA_W-1:0]    base_q;
  logic [PA_W-1:0]    l2_base_q;
  logic [IDX_MAX-1:0] lvl_idx  [LEVELS];
  logic [PA_W-1:0]    lvl_base [LEVELS];
  logic [PA_W-1:0]    lvl_addr [LEVELS];

  assign lvl_idx[0]  = IDX_MAX'(vaddr_q[VA_W-1 -: IDX1_W]);
  assign lvl_idx[1]  = IDX_MAX'(vaddr_q[OFF_W +: IDX2_W]);
  assign lvl_base[0] = base_q;
  assign lvl_base[1] = l2_base_q;

  for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
    pt_addr_gen #(
      .PA_W  (PA_W),
      .IDX_W (IDX_MAX),
      .ENT_SH(ENT_SH)
    ) u_addr (
      .table_base(lvl_base[g]),
      .idx       (lvl_idx[g]),
      .entry_addr(lvl_addr[g])
    );
  end

  logic [PFN_W-1:0] rsp_pfn;
  logic [PA_W-1:0]  rsp_frame;
  pte_flags_t       rsp_flags;

  pt_pte_decode #(
    .PTE_W(PTE_W),
    .OFF_W(OFF_W)
  ) u_decode (
    .raw       (mem_rsp_data),
    .pfn       (rsp_pfn),
    .frame_base(rsp_frame),
    .flags     (rsp_flags)
  );

  pt_walk_ctrl #(
    .VA_W (VA_W),
    .PA_W (PA_W),
    .PFN_W(PFN_W),
    .OFF_W(OFF_W)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_vaddr    (req_vaddr),
    .req_base     (req_base),
    .vaddr_q      (vaddr_q),
    .base_q       (base_q),
    .l2_base_q    (l2_base_q),
    .l1_addr      (lvl_addr[0]),
    .l2_addr      (lvl_addr[1]),
    .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready),
    .mem_req_addr (mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid),
    .rsp_flags    (rsp_flags),
    .rsp_pfn      (rsp_pfn),
    .rsp_frame    (rsp_frame),
    .walk_done    (walk_done),
    .walk_fault   (walk_fault),
    .fault_lvl    (fault_lvl),
    .res_pfn      (res_pfn),
    .res_paddr    (res_paddr),
    .res_perm     (res_perm),
    .res_dirty    (res_dirty),
    .res_ref      (res_ref)
  );

  // R10
  offset_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_done |-> (res_paddr[OFF_W-1:0] == vaddr_q[OFF_W-1:0]));

endmodule

// File: tb/test_pt_walker.sv
module test_pt_walker;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [31:0] req_base = '0;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        walk_done, walk_fault, fault_lvl;
  logic [19:0] res_pfn;
  logic [31:0] res_paddr;
  logic [2:0]  res_perm;
  logic        res_dirty, res_ref;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  pt_walker i_pt_walker (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_base(req_base),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .walk_done(walk_done), .walk_fault(walk_fault), .fault_lvl(fault_lvl),
    .res_pfn(res_pfn), .res_paddr(res_paddr), .res_perm(res_perm),
    .res_dirty(res_dirty), .res_ref(res_ref)
  );

  // ---------------- memory model ----------------
  logic [31:0] mem [0:4095];
  logic        stall_mode = 1'b0;
  int          latency = 0;
  logic [1:0]  gap = '0;
  logic        pend = 1'b0;
  int          cnt = 0;
  logic [31:0] addr_q = '0;
  int          nreads = 0;
  logic [31:0] rd_log [0:7];

  assign mem_req_ready = stall_mode ? (gap == 2'd0) : 1'b1;

  always @(posedge clk) begin
    gap <= (gap == 2'd2) ? 2'd0 : gap + 2'd1;
    mem_rsp_valid <= 1'b0;
    if (pend) begin
      if (cnt == 0) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= mem[addr_q[13:2]];
        pend <= 1'b0;
      end else cnt <= cnt - 1;
    end else if (mem_req_valid && mem_req_ready) begin
      pend   <= 1'b1;
      cnt    <= latency;
      addr_q <= mem_req_addr;
      rd_log[nreads[2:0]] <= mem_req_addr;
      nreads <= nreads + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // ---------------- one walk with its own checks ----------------
  task automatic walk(input logic [31:0] va, input logic [31:0] base,
                      input logic stall, input int lat, input logic poke, input string tag);
    logic [31:0] l1a, l2a, e1, e2;
    int exp_reads;
    logic exp_fault, exp_lvl;
    int r0;
    bit seen;
    logic got_done, got_fault, got_lvl;
    logic [19:0] g_pfn;
    logic [31:0] g_pa;
    logic [2:0] g_perm;
    logic g_dirty, g_ref;

    l1a = base + ((va >> 22) << 2);
    e1  = mem[l1a[13:2]];
    l2a = (e1 & 32'hFFFF_F000) + (((va >> 12) & 32'h3FF) << 2);
    e2  = mem[l2a[13:2]];
    if (!e1[0]) begin exp_reads = 1; exp_fault = 1; exp_lvl = 0; end
    else if (!e2[0]) begin exp_reads = 2; exp_fault = 1; exp_lvl = 1; end
    else begin exp_reads = 2; exp_fault = 0; exp_lvl = 0; end

    @(negedge clk);
    stall_mode = stall;
    latency    = lat;
    r0         = nreads;
    req_valid  = 1'b1;
    req_vaddr  = va;
    req_base   = base;
    @(negedge clk);
    req_valid  = 1'b0;
    if (poke) begin
      // R7: walker busy, a second request is offered and must be ignored
      req_valid = 1'b1;
      req_vaddr = va ^ 32'hFFC0_0FFF;
      req_base  = base + 32'h0000_1000;
      check({tag, " R7 ready low while busy"}, {31'd0, req_ready}, 32'd0);
    end
    seen = 0;
    for (int i = 0; i < 300; i++) begin
      if (walk_done || walk_fault) begin seen = 1; break; end
      @(negedge clk);
    end
    req_valid = 1'b0;
    got_done = walk_done; got_fault = walk_fault; got_lvl = fault_lvl;
    g_pfn = res_pfn; g_pa = res_paddr; g_perm = res_perm;
    g_dirty = res_dirty; g_ref = res_ref;
    check({tag, " R8 walk finished"}, {31'd0, seen}, 32'd1);
    check({tag, " R8 not both"}, {31'd0, got_done & got_fault}, 32'd0);
    check({tag, " R5 R6 fault flag"}, {31'd0, got_fault}, {31'd0, exp_fault});
    check({tag, " R4 done flag"}, {31'd0, got_done}, {31'd0, ~exp_fault});
    check({tag, " R3 read count"}, nreads - r0, exp_reads);
    check({tag, " R2 level-1 address"}, rd_log[r0[2:0]], l1a);
    if (exp_reads == 2)
      check({tag, " R3 level-2 address"}, rd_log[r0[2:0] + 3'd1], l2a);
    if (exp_fault)
      check({tag, " R5 R6 fault level"}, {31'd0, got_lvl}, {31'd0, exp_lvl});
    else begin
      check({tag, " R4 pfn"}, {12'd0, g_pfn}, {12'd0, e2[31:12]});
      check({tag, " R4 perm"}, {29'd0, g_perm}, {29'd0, e2[3], e2[2], e2[1]});
      check({tag, " R4 dirty"}, {31'd0, g_dirty}, {31'd0, e2[5]});
      check({tag, " R4 ref"}, {31'd0, g_ref}, {31'd0, e2[4]});
      check({tag, " R10 paddr"}, g_pa, {e2[31:12], va[11:0]});
    end
    @(negedge clk);
    check({tag, " R8 one-cycle pulse"}, {30'd0, walk_done, walk_fault}, 32'd0);
    check({tag, " R7 ready back in idle"}, {31'd0, req_ready}, 32'd1);
  endtask

  task automatic t_reset();
    check("R1 ready in reset", {31'd0, req_ready}, 32'd1);
    check("R1 no mem request", {31'd0, mem_req_valid}, 32'd0);
    check("R1 no done/fault", {30'd0, walk_done, walk_fault}, 32'd0);
  endtask

  task automatic t_basic();
    walk({10'h001, 10'h000, 12'h5A5}, 32'h1000, 1'b0, 0, 1'b0, "basic");
    walk({10'h001, 10'h3FF, 12'hFFF}, 32'h1000, 1'b0, 1, 1'b0, "idx-max-l2");
    walk({10'h3FF, 10'h155, 12'h000}, 32'h1000, 1'b0, 2, 1'b0, "idx-max-l1");
  endtask

  task automatic t_faults();
    walk({10'h005, 10'h010, 12'h123}, 32'h1000, 1'b0, 0, 1'b0, "R5 l1-fault");
    walk({10'h3FF, 10'h2AA, 12'h456}, 32'h1000, 1'b0, 3, 1'b0, "R6 l2-fault");
  endtask

  task automatic t_l1_flags();
    // R11: level-1 entry with every attribute bit set leads to a plain entry
    walk({10'h002, 10'h000, 12'h0AB}, 32'h1000, 1'b0, 0, 1'b0, "R11 l1-attrs");
  endtask

  task automatic t_stall();
    walk({10'h001, 10'h3FF, 12'h321}, 32'h1000, 1'b1, 5, 1'b0, "R9 stall");
    walk({10'h3FF, 10'h2AA, 12'h001}, 32'h1000, 1'b1, 4, 1'b0, "R9 stall-fault");
  endtask

  task automatic t_busy();
    walk({10'h3FF, 10'h155, 12'h777}, 32'h1000, 1'b1, 2, 1'b1, "R7 busy");
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 32'h0;
    for (int i = 0; i < 8; i++) rd_log[i] = 32'h0;
    // first-level table at 0x1000
    mem[12'h400 + 12'h001] = 32'h0000_2001;
    mem[12'h400 + 12'h3FF] = 32'h0000_3001;
    mem[12'h400 + 12'h002] = 32'h0000_203F;
    // second-level table at 0x2000
    mem[12'h800 + 12'h000] = 32'hABCD_E007;
    mem[12'h800 + 12'h3FF] = 32'h1234_5039;
    // second-level table at 0x3000
    mem[12'hC00 + 12'h155] = 32'hFFFF_F023;
    mem[12'hC00 + 12'h2AA] = 32'h7777_703E;

    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_faults();
    t_l1_flags();
    t_stall();
    t_busy();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #800000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule